// File: doc/BRIEF.md
# Lockstep PE Local Sequencer

This block is the control unit placed inside every processing element of a square mesh of multiply-accumulate engines that computes blocked matrix products as a run of rank-1 updates. Each copy knows its own row and column position in the mesh. All copies see the same start pulse, the same stall level and the same operation code, so they advance in lockstep and need no handshake between them. Each copy works out for itself when its element must broadcast on the row bus or the column bus.

A job begins with a start pulse in the idle state. The sequencer captures the operation code and three loop bounds. It then loads the element's A store and the current half of its B store. Next it runs one compute pass per block of C. Each pass is optionally preceded by an accumulator preload and optionally followed by an accumulator unload. A drain wait covers the multiply-accumulate pipeline. Between blocks the sequencer flips the B half it reads, provided the prefetch of the other half has completed; otherwise it holds and raises a stall request to the global controller. The memory arrays and the arithmetic are outside the block and are driven only through its enable and address outputs.

Top module: `lpe_seq`

## Requirements
- R1: After reset and while idle, every enable output, stall_req and done are 0.
- R2: A start pulse seen in the idle state (with stall low) captures op_sel, kc_preset, blk_preset and alen_preset. The load phase then runs for alen_preset cycles with a_en=a_we=1 and a_addr counting 0,1,...,alen_preset-1. Changes to these inputs, and start pulses, while not idle have no effect.
- R3: After the A load, the B load runs for kc_preset cycles with b_wr_en=1. b_wr_addr is {bank, index}: the bank bit is the MSB and is 0 for the first block, and the index counts 0..kc_preset-1.
- R4: Each block has a compute pass of kc_preset cycles with mac_en=b_rd_en=1. b_rd_addr is {bank, p} for step p=0..kc_preset-1. mac_en never coincides with an A/B load, an accumulator transfer or done.
- R5: During compute, row_drive is 1 exactly when col_idx equals p mod NR, and col_drive is 1 exactly when row_idx equals p mod NR. A diagonal element drives both buses.
- R6: During compute, the A store is read (a_en=1, a_we=0) only on row_drive cycles. The read address starts at 0 after the load and advances by one per read, continuing across blocks.
- R7: op_sel bit 0 set gives one acc_load cycle right before each compute pass. op_sel bit 1 set gives one acc_unload cycle right after each drain. A clear bit removes that cycle.
- R8: After each compute pass there are MAC_LAT drain cycles with no enable asserted.
- R9: Block k reads bank k mod 2. At the last drain cycle of a block that is not the final block, the sequencer moves on only if prefetch_done is 1. Otherwise it holds with stall_req=1 and all enables low. stall_req is 0 in every other case.
- R10: While stall is 1, every enable output and done are 0, and the sequencer state and addresses are frozen. The sequence resumes unchanged when stall returns to 0.
- R11: After the last block, done is 1 for exactly one cycle and the sequencer returns to idle, ready for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Global start pulse, used only in idle |
| stall | input | 1 | Global stall level, freezes the sequencer |
| op_sel | input | 2 | Operation code: bit 0 preload C, bit 1 unload C |
| kc_preset | input | CNT_W | Rank-1 steps per block (at least 1) |
| blk_preset | input | CNT_W | Number of C blocks (at least 1) |
| alen_preset | input | A_AW | Words loaded into the A store (at least 1) |
| row_idx | input | IDX_W | Row position of this element |
| col_idx | input | IDX_W | Column position of this element |
| prefetch_done | input | 1 | Next B half has been fully written |
| a_en | output | 1 | A store access enable |
| a_we | output | 1 | A store write (load) |
| a_addr | output | A_AW | A store address |
| b_wr_en | output | 1 | B store write port enable |
| b_wr_addr | output | CNT_W+1 | B write address {bank, index} |
| b_rd_en | output | 1 | B store read port enable |
| b_rd_addr | output | CNT_W+1 | B read address {bank, step} |
| row_drive | output | 1 | Drive own A element onto row bus |
| col_drive | output | 1 | Drive own B element onto column bus |
| mac_en | output | 1 | Multiply-accumulate enable |
| acc_load | output | 1 | Load accumulator from column bus |
| acc_unload | output | 1 | Put accumulator onto column bus |
| stall_req | output | 1 | Request for a global stall while waiting on prefetch |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
The bench varies the element's position so that it is off-diagonal, on the diagonal and at an edge. A bus-ownership decoder that compared the wrong index, or that failed to restart the modulo phase at each block, would drive a bus in the wrong step. It holds prefetch_done low across a block boundary: a design that swapped banks early would read the half still being written, and one that did not wait would lose the stall request. Stall pulses land inside loads and compute, and a design that kept counting would skip or repeat addresses. A run with a single step, a single block and a single A word exercises the first-equals-last case that off-by-one bounds would break. Presets and start are also changed mid-job, which a design that did not capture them would follow.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD_A,
    ST_LOAD_B,
    ST_PRELOAD_C,
    ST_COMPUTE,
    ST_DRAIN,
    ST_UNLOAD_C,
    ST_DONE
  } lpe_state_e;

  localparam int OP_W       = 2;
  localparam int OP_PRELOAD = 0;
  localparam int OP_UNLOAD  = 1;

endpackage

// File: rtl/lpe_addr_gen.sv
module lpe_addr_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] ptr
);

  logic [W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (clr)      ptr_d = '0;
    else if (inc) ptr_d = ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr <= '0;
    else if (en) ptr <= ptr_d;
  end

endmodule

// File: rtl/lpe_bus_own.sv
module lpe_bus_own #(
  parameter int NR    = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic             inc,
  input  logic [IDX_W-1:0] row_idx,
  input  logic [IDX_W-1:0] col_idx,
  output logic             row_hit,
  output logic             col_hit
);

  logic [IDX_W-1:0] ph_q, ph_d, ph_nxt;

  generate
    if ((NR & (NR - 1)) == 0) begin : g_pow2
      assign ph_nxt = ph_q + 1'b1;
    end else begin : g_wrap
      assign ph_nxt = (ph_q == IDX_W'(NR - 1)) ? '0 : ph_q + 1'b1;
    end
  endgenerate

  always_comb begin
    ph_d = ph_q;
    if (clr)      ph_d = '0;
    else if (inc) ph_d = ph_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ph_q <= '0;
    else if (en) ph_q <= ph_d;
  end

  assign row_hit = (ph_q == col_idx);
  assign col_hit = (ph_q == row_idx);

endmodule

// File: rtl/lpe_fsm.sv
module lpe_fsm
  import lpe_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int A_AW    = 10,
  parameter int MAC_LAT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             start,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [CNT_W-1:0] kc_preset,
  input  logic [CNT_W-1:0] blk_preset,
  input  logic [A_AW-1:0]  alen_preset,
  input  logic             prefetch_done,
  input  logic             row_hit,
  input  logic [A_AW-1:0]  a_ptr,
  input  logic [CNT_W-1:0] b_ptr,
  output lpe_state_e       state,
  output logic             bsel,
  output logic             a_clr,
  output logic             a_inc,
  output logic             b_clr,
  output logic             b_inc,
  output logic             ph_clr,
  output logic             ph_inc,
  output logic             stall_req
);

  localparam logic [CNT_W-1:0] DRAIN_LAST = CNT_W'(MAC_LAT - 1);

  lpe_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] blk_q, blk_d;
  logic             bsel_q, bsel_d;
  logic [CNT_W-1:0] kc_q, nblk_q;
  logic [A_AW-1:0]  alen_q;
  logic [OP_W-1:0]  op_q;
  logic             lat;
  logic             last_blk, drain_end;
  lpe_state_e       blk_entry;

  assign last_blk  = (blk_q == nblk_q - 1'b1);
  assign drain_end = (cnt_q == DRAIN_LAST);
  assign blk_entry = op_q[OP_PRELOAD] ? ST_PRELOAD_C : ST_COMPUTE;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    blk_d     = blk_q;
    bsel_d    = bsel_q;
    lat       = 1'b0;
    a_clr     = 1'b0;
    a_inc     = 1'b0;
    b_clr     = 1'b0;
    b_inc     = 1'b0;
    ph_clr    = 1'b0;
    ph_inc    = 1'b0;
    stall_req = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          lat    = 1'b1;
          a_clr  = 1'b1;
          b_clr  = 1'b1;
          ph_clr = 1'b1;
          blk_d  = '0;
          bsel_d = 1'b0;
          cnt_d  = '0;
          st_d   = ST_LOAD_A;
        end
      end
      ST_LOAD_A: begin
        a_inc = 1'b1;
        if (a_ptr == alen_q - 1'b1) begin
          a_clr = 1'b1;
          st_d  = ST_LOAD_B;
        end
      end
      ST_LOAD_B: begin
        b_inc = 1'b1;
        if (b_ptr == kc_q - 1'b1) begin
          b_clr  = 1'b1;
          ph_clr = 1'b1;
          st_d   = blk_entry;
        end
      end
      ST_PRELOAD_C: st_d = ST_COMPUTE;
      ST_COMPUTE: begin
        b_inc  = 1'b1;
        ph_inc = 1'b1;
        a_inc  = row_hit;
        if (b_ptr == kc_q - 1'b1) begin
          b_clr  = 1'b1;
          ph_clr = 1'b1;
          cnt_d  = '0;
          st_d   = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!drain_end) begin
          cnt_d = cnt_q + 1'b1;
        end else if (last_blk) begin
          st_d = op_q[OP_UNLOAD] ? ST_UNLOAD_C : ST_DONE;
        end else if (prefetch_done) begin
          bsel_d = ~bsel_q;
          if (op_q[OP_UNLOAD]) begin
            st_d = ST_UNLOAD_C;
          end else begin
            blk_d = blk_q + 1'b1;
            st_d  = blk_entry;
          end
        end else begin
          stall_req = 1'b1;
        end
      end
      ST_UNLOAD_C: begin
        if (last_blk) begin
          st_d = ST_DONE;
        end else begin
          blk_d = blk_q + 1'b1;
          st_d  = blk_entry;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      blk_q  <= '0;
      bsel_q <= 1'b0;
    end else if (adv) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      blk_q  <= blk_d;
      bsel_q <= bsel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kc_q   <= '0;
      nblk_q <= '0;
      alen_q <= '0;
      op_q   <= '0;
    end else if (adv && lat) begin
      kc_q   <= kc_preset;
      nblk_q <= blk_preset;
      alen_q <= alen_preset;
      op_q   <= op_sel;
    end
  end

  assign state = st_q;
  assign bsel  = bsel_q;

endmodule

// File: rtl/lpe_seq.sv
module lpe_seq
  import lpe_pkg::*;
#(
  parameter int NR      = 4,
  parameter int CNT_W   = 8,
  parameter int A_AW    = 10,
  parameter int MAC_LAT = 4,
  localparam int IDX_W  = (NR > 1) ? $clog2(NR) : 1,
  localparam int B_AW   = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stall,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [CNT_W-1:0] kc_preset,
  input  logic [CNT_W-1:0] blk_preset,
  input  logic [A_AW-1:0]  alen_preset,
  input  logic [IDX_W-1:0] row_idx,
  input  logic [IDX_W-1:0] col_idx,
  input  logic             prefetch_done,
  output logic             a_en,
  output logic             a_we,
  output logic [A_AW-1:0]  a_addr,
  output logic             b_wr_en,
  output logic [B_AW-1:0]  b_wr_addr,
  output logic             b_rd_en,
  output logic [B_AW-1:0]  b_rd_addr,
  output logic             row_drive,
  output logic             col_drive,
  output logic             mac_en,
  output logic             acc_load,
  output logic             acc_unload,
  output logic             stall_req,
  output logic             done
);

  logic             adv;
  lpe_state_e       st;
  logic             bsel;
  logic             a_clr, a_inc, b_clr, b_inc, ph_clr, ph_inc;
  logic             row_hit, col_hit;
  logic [A_AW-1:0]  a_ptr;
  logic [CNT_W-1:0] b_ptr;
  logic             in_cmp;

  assign adv = ~stall;

  lpe_fsm #(
    .CNT_W   (CNT_W),
    .A_AW    (A_AW),
    .MAC_LAT (MAC_LAT)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .adv           (adv),
    .start         (start),
    .op_sel        (op_sel),
    .kc_preset     (kc_preset),
    .blk_preset    (blk_preset),
    .alen_preset   (alen_preset),
    .prefetch_done (prefetch_done),
    .row_hit       (row_hit),
    .a_ptr         (a_ptr),
    .b_ptr         (b_ptr),
    .state         (st),
    .bsel          (bsel),
    .a_clr         (a_clr),
    .a_inc         (a_inc),
    .b_clr         (b_clr),
    .b_inc         (b_inc),
    .ph_clr        (ph_clr),
    .ph_inc        (ph_inc),
    .stall_req     (stall_req)
  );

  lpe_addr_gen #(.W(A_AW)) u_a_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .clr   (a_clr),
    .inc   (a_inc),
    .ptr   (a_ptr)
  );

  lpe_addr_gen #(.W(CNT_W)) u_b_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (adv),
    .clr   (b_clr),
    .inc   (b_inc),
    .ptr   (b_ptr)
  );

  lpe_bus_own #(.NR(NR), .IDX_W(IDX_W)) u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (adv),
    .clr     (ph_clr),
    .inc     (ph_inc),
    .row_idx (row_idx),
    .col_idx (col_idx),
    .row_hit (row_hit),
    .col_hit (col_hit)
  );

  assign in_cmp     = (st == ST_COMPUTE);
  assign a_we       = adv & (st == ST_LOAD_A);
  assign a_en       = adv & ((st == ST_LOAD_A) | (in_cmp & row_hit));
  assign a_addr     = a_ptr;
  assign b_wr_en    = adv & (st == ST_LOAD_B);
  assign b_wr_addr  = {bsel, b_ptr};
  assign b_rd_en    = adv & in_cmp;
  assign b_rd_addr  = {bsel, b_ptr};
  assign row_drive  = adv & in_cmp & row_hit;
  assign col_drive  = adv & in_cmp & col_hit;
  assign mac_en     = adv & in_cmp;
  assign acc_load   = adv & (st == ST_PRELOAD_C);
  assign acc_unload = adv & (st == ST_UNLOAD_C);
  assign done       = adv & (st == ST_DONE);

endmodule

// File: rtl/lpe_seq_chk.sv
module lpe_seq_chk #(
  parameter int CNT_W = 8,
  parameter int A_AW  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             prefetch_done,
  input logic             a_en,
  input logic             a_we,
  input logic [A_AW-1:0]  a_addr,
  input logic             b_wr_en,
  input logic [CNT_W:0]   b_wr_addr,
  input logic             b_rd_en,
  input logic [CNT_W:0]   b_rd_addr,
  input logic             row_drive,
  input logic             col_drive,
  input logic             mac_en,
  input logic             acc_load,
  input logic             acc_unload,
  input logic             stall_req,
  input logic             done
);

  assert_load_a_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_we |=> (!a_we || a_addr == $past(a_addr) + 1'b1));

  assert_load_b_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr_en |=> (!b_wr_en || b_wr_addr[CNT_W-1:0] == $past(b_wr_addr[CNT_W-1:0]) + 1'b1));

  assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_we, b_wr_en, mac_en, acc_load, acc_unload, done}));

  assert_drive_in_compute_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_drive || col_drive) |-> mac_en);

  assert_a_read_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_drive |=> a_addr == $past(a_addr) + 1'b1);

  assert_a_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !row_drive) |=> a_addr == $past(a_addr));

  assert_wait_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !prefetch_done && !stall) |=> !(mac_en || acc_load || acc_unload || done));

  assert_stall_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !(a_en || b_wr_en || b_rd_en || mac_en || row_drive || col_drive ||
                acc_load || acc_unload || done));

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(a_addr) && $stable(b_rd_addr)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind lpe_seq lpe_seq_chk #(.CNT_W(CNT_W), .A_AW(A_AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall         (stall),
  .prefetch_done (prefetch_done),
  .a_en          (a_en),
  .a_we          (a_we),
  .a_addr        (a_addr),
  .b_wr_en       (b_wr_en),
  .b_wr_addr     (b_wr_addr),
  .b_rd_en       (b_rd_en),
  .b_rd_addr     (b_rd_addr),
  .row_drive     (row_drive),
  .col_drive     (col_drive),
  .mac_en        (mac_en),
  .acc_load      (acc_load),
  .acc_unload    (acc_unload),
  .stall_req     (stall_req),
  .done          (done)
);

// File: tb/tb_lpe_seq.sv
module tb_lpe_seq;

  localparam int NR      = 4;
  localparam int CNT_W   = 8;
  localparam int A_AW    = 10;
  localparam int MAC_LAT = 4;
  localparam int IDX_W   = 2;

  localparam int M_IDLE = 0, M_LA = 1, M_LB = 2, M_PC = 3,
                 M_CP = 4, M_DR = 5, M_UC = 6, M_DN = 7;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic             stall;
  logic [1:0]       op_sel;
  logic [CNT_W-1:0] kc_preset;
  logic [CNT_W-1:0] blk_preset;
  logic [A_AW-1:0]  alen_preset;
  logic [IDX_W-1:0] row_idx;
  logic [IDX_W-1:0] col_idx;
  logic             prefetch_done;
  logic             a_en, a_we, b_wr_en, b_rd_en;
  logic [A_AW-1:0]  a_addr;
  logic [CNT_W:0]   b_wr_addr, b_rd_addr;
  logic             row_drive, col_drive, mac_en, acc_load, acc_unload, stall_req, done;

  lpe_seq #(.NR(NR), .CNT_W(CNT_W), .A_AW(A_AW), .MAC_LAT(MAC_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stall(stall), .op_sel(op_sel),
    .kc_preset(kc_preset), .blk_preset(blk_preset), .alen_preset(alen_preset),
    .row_idx(row_idx), .col_idx(col_idx), .prefetch_done(prefetch_done),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .b_wr_en(b_wr_en),
    .b_wr_addr(b_wr_addr), .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr),
    .row_drive(row_drive), .col_drive(col_drive), .mac_en(mac_en),
    .acc_load(acc_load), .acc_unload(acc_unload), .stall_req(stall_req), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  // behavioural reference state
  int m_st = M_IDLE;
  int m_kc, m_nb, m_al, m_op;
  int m_a, m_b, m_blk, m_bank, m_cnt;
  int pf_delay = 0, stall_per = 0, wait_cnt = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit waiting();
    return (m_st == M_DR) && (m_cnt == MAC_LAT - 1) && (m_blk != m_nb - 1);
  endfunction

  task automatic compare();
    bit g, own_r, own_c;
    logic [10:0] ev, av;
    string tag;
    g     = !stall;
    own_r = (m_st == M_CP) && ((m_b % NR) == int'(col_idx));
    own_c = (m_st == M_CP) && ((m_b % NR) == int'(row_idx));
    ev = {g && (m_st == M_LA || own_r), g && m_st == M_LA, g && m_st == M_LB,
          g && m_st == M_CP, g && own_r, g && own_c, g && m_st == M_CP,
          g && m_st == M_PC, g && m_st == M_UC, waiting() && !prefetch_done,
          g && m_st == M_DN};
    av = {a_en, a_we, b_wr_en, b_rd_en, row_drive, col_drive, mac_en,
          acc_load, acc_unload, stall_req, done};
    if (stall) tag = "R10";
    else case (m_st)
      M_IDLE: tag = "R1";
      M_LA:   tag = "R2";
      M_LB:   tag = "R3";
      M_PC, M_UC: tag = "R7";
      M_CP:   tag = "R4";
      M_DR:   tag = waiting() ? "R9" : "R8";
      default: tag = "R11";
    endcase
    chk(tag, "controls", 32'(av), 32'(ev));
    if (g && m_st == M_CP) begin
      chk("R5", "drives", {30'd0, row_drive, col_drive}, {30'd0, own_r, own_c});
      chk("R6", "a_en", {31'd0, a_en}, {31'd0, own_r});
      chk("R4", "b_rd_idx", 32'(b_rd_addr[CNT_W-1:0]), 32'(m_b));
      chk("R9", "b_rd_bank", {31'd0, b_rd_addr[CNT_W]}, 32'(m_bank));
    end
    if (g && (m_st == M_LA || own_r))
      chk(m_st == M_LA ? "R2" : "R6", "a_addr", 32'(a_addr), 32'(m_a));
    if (g && m_st == M_LB)
      chk("R3", "b_wr_addr", 32'(b_wr_addr), 32'((m_bank << CNT_W) | m_b));
  endtask

  task automatic model_step();
    int nxt;
    if (stall) return;
    nxt = (m_op & 1) ? M_PC : M_CP;
    case (m_st)
      M_IDLE: if (start) begin
        m_kc = int'(kc_preset); m_nb = int'(blk_preset); m_al = int'(alen_preset);
        m_op = int'(op_sel); m_a = 0; m_b = 0; m_blk = 0; m_bank = 0; m_cnt = 0;
        m_st = M_LA;
      end
      M_LA: if (m_a == m_al - 1) begin m_a = 0; m_st = M_LB; end else m_a++;
      M_LB: if (m_b == m_kc - 1) begin m_b = 0; m_st = nxt; end else m_b++;
      M_PC: m_st = M_CP;
      M_CP: begin
        if ((m_b % NR) == int'(col_idx)) m_a++;
        if (m_b == m_kc - 1) begin m_b = 0; m_cnt = 0; m_st = M_DR; end else m_b++;
      end
      M_DR: begin
        if (m_cnt < MAC_LAT - 1) m_cnt++;
        else if (m_blk == m_nb - 1) m_st = (m_op & 2) ? M_UC : M_DN;
        else if (prefetch_done) begin
          m_bank ^= 1;
          if (m_op & 2) m_st = M_UC;
          else begin m_blk++; m_st = nxt; end
        end
      end
      M_UC: if (m_blk == m_nb - 1) m_st = M_DN; else begin m_blk++; m_st = nxt; end
      default: m_st = M_IDLE;
    endcase
  endtask

  task automatic tick();
    stall = (stall_per != 0) && !start && ((cyc % stall_per) == 3);
    prefetch_done = (wait_cnt >= pf_delay);
    #1 compare();
    @(posedge clk);
    if (waiting()) wait_cnt++; else wait_cnt = 0;
    model_step();
    if (!waiting()) wait_cnt = 0;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(int op, int kc, int nb, int al, int ri, int ci,
                     int pfd, int sp, bit meddle);
    row_idx = IDX_W'(ri); col_idx = IDX_W'(ci); op_sel = 2'(op);
    kc_preset = CNT_W'(kc); blk_preset = CNT_W'(nb); alen_preset = A_AW'(al);
    pf_delay = pfd; stall_per = sp;
    start = 1'b1;
    tick();
    start = 1'b0;
    while (m_st != M_IDLE) begin
      if (meddle && m_st == M_CP) begin
        // R2: presets and start ignored while busy
        kc_preset = CNT_W'(2); op_sel = 2'd0; start = 1'b1;
      end
      tick();
      start = 1'b0;
    end
    tick();
    tick();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; stall = 1'b0; op_sel = '0; kc_preset = '0;
    blk_preset = '0; alen_preset = '0; row_idx = '0; col_idx = '0; prefetch_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    chk("R1", "reset controls",
        32'({a_en, a_we, b_wr_en, b_rd_en, row_drive, col_drive, mac_en,
             acc_load, acc_unload, stall_req, done}), 32'd0);
    rst_n = 1'b1;
    tick();
    tick();
    run(3, 6, 2, 3, 1, 2, 0, 0, 1'b0);   // full op, off-diagonal
    run(0, 5, 3, 2, 2, 2, 3, 0, 1'b0);   // diagonal, prefetch late
    run(1, 9, 2, 4, 0, 3, 1, 7, 1'b1);   // stalls, mid-run meddling
    run(2, 1, 1, 1, 3, 0, 0, 0, 1'b0);   // single step, single block
    run(3, 4, 3, 2, 3, 3, 2, 5, 1'b0);   // stalls while waiting on prefetch
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule